// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit decides how long a vector operation really was after a data-dependent early-exit scan. It is given a requested vector length counted in sub-groups, a sub-group width of one to four elements, a per-element predicate mask with its zeroing flag, and one fail indication per element. The fail bits are either comparison results (conditional-test mode) or access faults (memory-fault mode). It scans the active elements in order and returns the number of whole sub-groups that completed before the first failure.

A pulse on `start` samples every input. One clock later `done` pulses and the registered result appears: the new vector length, a flag that says it was shortened, and a trap request. The trap request is raised only when a memory fault hits the very first sub-group, because no progress can be reported in that case. The result stays on the outputs until the next `start`. The memory access, the comparators and the register writeback stay outside the unit.

Top module: `failfirst_len_unit`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `start` high. Outputs `vl_out`, `truncated` and `trap` change only in that cycle and keep their values until the next result.
- R2: A synchronous active-high `rst` clears `done`, `vl_out`, `truncated` and `trap` to zero.
- R3: When no active element fails, `vl_out` equals the requested length and `truncated` and `trap` are 0. A requested length above MAX_VL (16 by default) is clamped to MAX_VL.
- R4: With `fault_mode`=0 and `zero_mode`=0, an element whose mask bit is 0 never fails, whatever its fail bit is.
- R5: With `fault_mode`=0 and `zero_mode`=1, an active element whose mask bit is 0 always fails.
- R6: With `fault_mode`=1, an element whose mask bit is 0 never fails, and the value of `zero_mode` has no effect on any output.
- R7: Element k of sub-group g sits at bit g*S+k of `mask_in` and `fail_in`, where S is the effective sub-group width. A failure anywhere in sub-group g removes the whole sub-group, so `vl_out`=g and `truncated`=1 (except as given in R8).
- R8: With `fault_mode`=1, a failure in sub-group 0 gives `trap`=1, `truncated`=0 and `vl_out` equal to the (clamped) requested length. A failure in a later sub-group truncates as in R7 with `trap`=0. With `fault_mode`=0, `trap` is never 1.
- R9: A `subvl_in` value outside 1..4 acts as 1. Element bits at or beyond (clamped length)*S are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample inputs and compute a result |
| vl_in | input | 5 | Requested length in sub-groups |
| subvl_in | input | 3 | Sub-group width, 1..4 |
| mask_in | input | 64 | Per-element predicate, 1 = element enabled |
| zero_mode | input | 1 | 1 = zeroing predication |
| fault_mode | input | 1 | 0 = conditional test, 1 = memory fault |
| fail_in | input | 64 | Per-element fail or fault indication |
| done | output | 1 | One-cycle result strobe |
| vl_out | output | 5 | New length in whole sub-groups |
| truncated | output | 1 | Length was shortened |
| trap | output | 1 | Fault in first sub-group, trap requested |

## Verification
Because the unit is a single registered stage, any fault in its internal state shows up on `vl_out`, `truncated` or `trap` in the `done` cycle of the same operation. A wrong sub-group boundary selection typically gives a `vl_out` off by one sub-group, or a missed truncation. A wrong masking rule shows as a truncation that should not happen (or one that is missing) for a masked element. A stale or leaking register shows as an output that moves in a cycle without `done`.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  typedef enum logic {
    MODE_COND  = 1'b0,
    MODE_FAULT = 1'b1
  } ffl_mode_e;

  function automatic logic masked_fails(input logic zero_mode, input logic fault_mode);
    return zero_mode && (ffl_mode_e'(fault_mode) == MODE_COND);
  endfunction
endpackage

// File: rtl/ffl_elem_eval.sv
module ffl_elem_eval #(
  parameter int NELEM = 64,
  parameter int EW    = 7
) (
  input  logic [NELEM-1:0] mask,
  input  logic [NELEM-1:0] fail,
  input  logic [EW-1:0]    elem_cnt,
  input  logic             zero_mode,
  input  logic             fault_mode,
  output logic [NELEM-1:0] efail
);
  logic off_fails;
  assign off_fails = ffl_pkg::masked_fails(zero_mode, fault_mode);

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    logic active;
    assign active   = (EW'(e) < elem_cnt);
    assign efail[e] = active & (mask[e] ? fail[e] : off_fails);
  end
endmodule

// File: rtl/ffl_group_reduce.sv
module ffl_group_reduce #(
  parameter int MAX_VL  = 16,
  parameter int MAX_SUB = 4,
  localparam int NELEM  = MAX_VL * MAX_SUB
) (
  input  logic [NELEM-1:0]   efail,
  input  logic [MAX_SUB-1:0] sub_onehot,
  output logic [MAX_VL-1:0]  gfail
);
  for (genvar g = 0; g < MAX_VL; g++) begin : g_grp
    logic [MAX_SUB-1:0] by_width;
    for (genvar s = 1; s <= MAX_SUB; s++) begin : g_w
      assign by_width[s-1] = |efail[g*s +: s];
    end
    assign gfail[g] = |(by_width & sub_onehot);
  end
endmodule

// File: rtl/ffl_first_find.sv
module ffl_first_find #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/failfirst_len_unit.sv
module failfirst_len_unit #(
  parameter int MAX_VL  = 16,
  parameter int MAX_SUB = 4,
  localparam int NELEM  = MAX_VL * MAX_SUB,
  localparam int VLW    = $clog2(MAX_VL + 1),
  localparam int SW     = $clog2(MAX_SUB + 1),
  localparam int EW     = $clog2(NELEM + 1),
  localparam int IW     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VLW-1:0]   vl_in,
  input  logic [SW-1:0]    subvl_in,
  input  logic [NELEM-1:0] mask_in,
  input  logic             zero_mode,
  input  logic             fault_mode,
  input  logic [NELEM-1:0] fail_in,
  output logic             done,
  output logic [VLW-1:0]   vl_out,
  output logic             truncated,
  output logic             trap
);
  logic [VLW-1:0]     vl_c;
  logic [SW-1:0]      s_eff;
  logic [MAX_SUB-1:0] sub_onehot;
  logic [EW-1:0]      elem_cnt;
  logic [NELEM-1:0]   efail;
  logic [MAX_VL-1:0]  gfail;
  logic               found;
  logic [IW-1:0]      first_idx;
  logic               trap_n, trunc_n;
  logic [VLW-1:0]     vl_n;

  always_comb begin
    vl_c  = (vl_in > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_in;
    s_eff = (subvl_in >= SW'(1) && subvl_in <= SW'(MAX_SUB)) ? subvl_in : SW'(1);
    for (int i = 0; i < MAX_SUB; i++) sub_onehot[i] = (s_eff == SW'(i + 1));
    elem_cnt = EW'(vl_c) * EW'(s_eff);
  end

  ffl_elem_eval #(.NELEM(NELEM), .EW(EW)) u_eval (
    .mask(mask_in), .fail(fail_in), .elem_cnt(elem_cnt),
    .zero_mode(zero_mode), .fault_mode(fault_mode), .efail(efail)
  );

  ffl_group_reduce #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_reduce (
    .efail(efail), .sub_onehot(sub_onehot), .gfail(gfail)
  );

  ffl_first_find #(.N(MAX_VL), .IW(IW)) u_find (
    .req(gfail), .found(found), .idx(first_idx)
  );

  always_comb begin
    trap_n  = found && fault_mode && (first_idx == '0);
    trunc_n = found && !trap_n;
    vl_n    = trunc_n ? VLW'(first_idx) : vl_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      vl_out    <= '0;
      truncated <= 1'b0;
      trap      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        vl_out    <= vl_n;
        truncated <= trunc_n;
        trap      <= trap_n;
      end
    end
  end
endmodule

// File: rtl/ffl_checker.sv
module ffl_checker #(
  parameter int MAX_VL = 16,
  parameter int VLW    = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [VLW-1:0] vl_in,
  input logic           fault_mode,
  input logic           done,
  input logic [VLW-1:0] vl_out,
  input logic           truncated,
  input logic           trap
);
  assert_done_after_start_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_done_needs_start_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));
  assert_hold_result_R1: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable({vl_out, truncated, trap}));
  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> (!done && vl_out == '0 && !truncated && !trap));
  assert_trunc_shorter_R7: assert property (@(posedge clk) disable iff (rst)
    (done && truncated) |-> (vl_out < $past(vl_in)));
  assert_trap_only_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (done && trap) |-> $past(fault_mode));
  assert_trap_not_trunc_R8: assert property (@(posedge clk) disable iff (rst)
    trap |-> !truncated);
  assert_vl_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    vl_out <= VLW'(MAX_VL));
endmodule

bind failfirst_len_unit ffl_checker #(.MAX_VL(MAX_VL), .VLW(VLW)) u_ffl_checker (
  .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .fault_mode(fault_mode),
  .done(done), .vl_out(vl_out), .truncated(truncated), .trap(trap)
);

// File: tb/test_failfirst_len_unit.sv
module test_failfirst_len_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  vl_in = '0;
  logic [2:0]  subvl_in = '0;
  logic [63:0] mask_in = '0;
  logic        zero_mode = 1'b0;
  logic        fault_mode = 1'b0;
  logic [63:0] fail_in = '0;
  logic        done;
  logic [4:0]  vl_out;
  logic        truncated;
  logic        trap;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  failfirst_len_unit i_failfirst_len_unit (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .subvl_in(subvl_in),
    .mask_in(mask_in), .zero_mode(zero_mode), .fault_mode(fault_mode),
    .fail_in(fail_in), .done(done), .vl_out(vl_out), .truncated(truncated),
    .trap(trap)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic void model(input int vl, input int s, input logic [63:0] m,
                                input logic [63:0] f, input bit zm, input bit fm,
                                output int evl, output bit etr, output bit etp);
    int vlc, sc, first;
    vlc = (vl > 16) ? 16 : vl;
    sc  = (s < 1 || s > 4) ? 1 : s;
    first = -1;
    for (int g = 0; g < vlc; g++)
      for (int k = 0; k < sc; k++) begin
        int e;
        bit bad_e;
        e = g * sc + k;
        bad_e = m[e] ? f[e] : (!fm && zm);
        if (bad_e && first < 0) first = g;
      end
    etp = 0; etr = 0; evl = vlc;
    if (first >= 0) begin
      if (fm && first == 0) etp = 1;
      else begin evl = first; etr = 1; end
    end
  endfunction

  task automatic run(input string req, input int vl, input int s, input logic [63:0] m,
                     input logic [63:0] f, input bit zm, input bit fm);
    int evl; bit etr, etp;
    model(vl, s, m, f, zm, fm, evl, etr, etp);
    @(negedge clk);
    vl_in = 5'(vl); subvl_in = 3'(s); mask_in = m; fail_in = f;
    zero_mode = zm; fault_mode = fm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fail_in = ~f; mask_in = ~m;
    chk(done === 1'b1, {req, " R1 done"}, int'(done), 1);
    chk(vl_out === 5'(evl), {req, " vl_out"}, int'(vl_out), evl);
    chk(truncated === etr, {req, " truncated"}, int'(truncated), int'(etr));
    chk(trap === etp, {req, " trap"}, int'(trap), int'(etp));
    @(negedge clk);
    chk(done === 1'b0 && vl_out === 5'(evl), "R1 hold", int'(vl_out), evl);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog R1 got=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && vl_out === '0 && truncated === 1'b0 && trap === 1'b0,
        "R2 reset", int'(vl_out), 0);
    rst = 1'b0;
    @(negedge clk);

    run("R3 no fail", 16, 4, '1, '0, 1'b1, 1'b0);
    run("R3 clamp", 20, 1, '1, '0, 1'b0, 1'b0);
    run("R4 masked nonzero", 12, 2, '0, '1, 1'b0, 1'b0);
    run("R5 masked zeroing", 8, 2, ~(64'd1 << 5), '0, 1'b1, 1'b0);
    run("R6 fault zm1", 10, 2, '0, '1, 1'b1, 1'b1);
    run("R6 fault zm0", 10, 2, '0, '1, 1'b0, 1'b1);
    run("R7 subgroup 3", 5, 3, '1, 64'd1 << 7, 1'b0, 1'b0);
    run("R7 first group cond", 6, 4, '1, 64'd1 << 2, 1'b0, 1'b0);
    run("R8 trap", 9, 2, '1, 64'd1 << 1, 1'b0, 1'b1);
    run("R8 later fault", 9, 2, '1, 64'd1 << 4, 1'b0, 1'b1);
    run("R9 subvl 0", 8, 0, '1, 64'd1 << 3, 1'b0, 1'b0);
    run("R9 subvl 7", 8, 7, '1, 64'd1 << 3, 1'b0, 1'b0);
    run("R9 beyond vl", 3, 1, '1, 64'd1 << 5, 1'b0, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] m, f;
      m = {$urandom(), $urandom()} | {$urandom(), $urandom()};
      f = {$urandom(), $urandom()} & {$urandom(), $urandom()} &
          {$urandom(), $urandom()} & {$urandom(), $urandom()};
      run("R7 random", int'($urandom_range(0, 31)), int'($urandom_range(0, 7)),
          m, f, 1'($urandom()), 1'($urandom()));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule